// File: doc/BRIEF.md
# Six-Decade BCD Up Counter with Overflow Flag

This block counts events in decimal across six cascaded BCD decades. It forms the upper six digit positions of an eight-digit count display. Two input pins are ORed to make the internal count clock. When the two low digits come from an external prescaler, its two upper bits drive both pins. When the block counts on its own, one pin carries the events and the other is tied low. Each falling edge of the ORed clock adds one to the least significant decade, and a decade that passes 9 carries into the next one.

A separate sticky overflow flag has its own input. Its first falling edge sets the flag. The flag then holds until the counter clear, which is active low, is asserted. The clear also zeroes every decade. The most significant bit of the three upper decades is brought out so that one of them can be wired back as the overflow source. All asynchronous inputs are sampled on a fast system clock, and edges are detected from the sampled history.

Top module: `bcd_ripple_tally`

## Requirements
- R1: Each digit output holds a BCD value from 0 to 9. `digits_o[0]` is the least significant decade and `digits_o[5]` the most significant.
- R2: Each falling edge of (`pre_a` OR `pre_b`) adds exactly one to the count. A rising edge, or a steady level, leaves the count unchanged.
- R3: Either count pin works alone while the other is held low.
- R4: When the two pins overlap so that the OR stays high while one falls and the other rises, no count occurs. The count happens only when the OR finally falls.
- R5: A decade that steps from 9 wraps to 0 and adds one to the next higher decade in the same update.
- R6: When every decade holds 9, the next count returns all decades to 0.
- R7: While `clear_n` is low, all digits read 0, `ovf_o` reads 0, and count edges are ignored. Counting resumes on the first falling edge after release.
- R8: `ovf_o` sets on the first falling edge of `ovf_in` and stays set through any later activity until `clear_n` goes low.
- R9: A rising edge or a steady high on `ovf_in` does not set `ovf_o`.
- R10: `taps_o[k]` equals bit 3 (the MSB) of `digits_o[3+k]`, for k = 0..2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| clear_n | input | 1 | Active-low clear of the decades and the overflow flag |
| pre_a | input | 1 | Count pin A, ORed into the count clock |
| pre_b | input | 1 | Count pin B, ORed into the count clock |
| ovf_in | input | 1 | Overflow event input, falling-edge sensitive |
| digits_o | output | 6x4 | BCD digits, index 0 least significant |
| ovf_o | output | 1 | Sticky overflow flag |
| taps_o | output | 3 | MSB of each of the three upper decades |

## Verification
The bench drives overlapping pulses on the two count pins. A design that ORed the pins after edge detection would count twice there, and one that ignored a pin would miss counts. It climbs past 999 and to 8000 to check that carries ripple and that the upper-decade MSB taps rise at the right count. It also runs a two-decade copy of the block through 99 to 00, which catches a wrong wrap value. Finally it toggles the count pins during clear and raises `ovf_in` without letting it fall. A design that counted during clear, or set the flag on a rising edge, would fail these checks.

// File: rtl/tally_pkg.sv
package tally_pkg;
    typedef logic [3:0] bcd_t;

    localparam bcd_t BCD_TOP = 4'd9;

    function automatic bcd_t bcd_next(input bcd_t v);
        return (v == BCD_TOP) ? '0 : v + 4'd1;
    endfunction
endpackage

// File: rtl/tally_fall_detect.sv
module tally_fall_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clear_n,
    input  logic raw_i,
    output logic fall_o
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } fd_state_t;

    fd_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], raw_i};
        st_d.prev = st_q.sync[LAST];
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) st_q <= '0;
        else          st_q <= st_d;
    end

    assign fall_o = st_q.prev & ~st_q.sync[LAST];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!clear_n)
        fall_o |=> !fall_o); // R2
endmodule

// File: rtl/tally_decade.sv
module tally_decade
    import tally_pkg::*;
(
    input  logic clk,
    input  logic clear_n,
    input  logic step_i,
    output bcd_t digit_o,
    output logic carry_o
);
    typedef struct packed {
        bcd_t digit;
    } dec_state_t;

    dec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) st_d.digit = bcd_next(st_q.digit);
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) st_q <= '0;
        else          st_q <= st_d;
    end

    assign digit_o = st_q.digit;
    assign carry_o = step_i && (st_q.digit == BCD_TOP);

    AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!clear_n)
        digit_o <= BCD_TOP); // R1
    AST_DIGIT_HOLD: assert property (@(posedge clk) disable iff (!clear_n)
        !step_i |=> $stable(digit_o)); // R2
    AST_DIGIT_ROLL: assert property (@(posedge clk) disable iff (!clear_n)
        (step_i && digit_o == BCD_TOP) |=> digit_o == 4'd0); // R5
endmodule

// File: rtl/tally_ovf_flag.sv
module tally_ovf_flag (
    input  logic clk,
    input  logic clear_n,
    input  logic fall_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } ovf_state_t;

    ovf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fall_i) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) st_q <= '0;
        else          st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!clear_n)
        flag_o |=> flag_o); // R8
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!clear_n)
        $rose(flag_o) |-> $past(fall_i)); // R9
endmodule

// File: rtl/bcd_ripple_tally.sv
module bcd_ripple_tally
    import tally_pkg::*;
#(
    parameter int NUM_DECADES = 6,
    parameter int SYNC_STAGES = 2,
    parameter int TAP_FIRST   = 3,
    parameter int NUM_TAPS    = 3
) (
    input  logic                        clk,
    input  logic                        clear_n,
    input  logic                        pre_a,
    input  logic                        pre_b,
    input  logic                        ovf_in,
    output logic [NUM_DECADES-1:0][3:0] digits_o,
    output logic                        ovf_o,
    output logic [NUM_TAPS-1:0]         taps_o
);
    localparam int MSB_BIT = 3;

    logic                 cnt_raw;
    logic                 cnt_fall;
    logic                 ovf_fall;
    logic [NUM_DECADES:0] carry;

    assign cnt_raw  = pre_a | pre_b;
    assign carry[0] = cnt_fall;

    tally_fall_detect #(.STAGES(SYNC_STAGES)) u_cnt_edge (
        .clk    (clk),
        .clear_n(clear_n),
        .raw_i  (cnt_raw),
        .fall_o (cnt_fall)
    );

    tally_fall_detect #(.STAGES(SYNC_STAGES)) u_ovf_edge (
        .clk    (clk),
        .clear_n(clear_n),
        .raw_i  (ovf_in),
        .fall_o (ovf_fall)
    );

    for (genvar gi = 0; gi < NUM_DECADES; gi++) begin : g_dec
        tally_decade u_dec (
            .clk    (clk),
            .clear_n(clear_n),
            .step_i (carry[gi]),
            .digit_o(digits_o[gi]),
            .carry_o(carry[gi+1])
        );
    end

    for (genvar gt = 0; gt < NUM_TAPS; gt++) begin : g_tap
        assign taps_o[gt] = digits_o[TAP_FIRST+gt][MSB_BIT];
    end

    tally_ovf_flag u_ovf (
        .clk    (clk),
        .clear_n(clear_n),
        .fall_i (ovf_fall),
        .flag_o (ovf_o)
    );

    AST_CLEAR_ZERO: assert property (@(posedge clk)
        !clear_n |-> (digits_o == '0 && !ovf_o)); // R7
    AST_LSD_STEP: assert property (@(posedge clk) disable iff (!clear_n)
        (digits_o[0] != $past(digits_o[0])) |->
        digits_o[0] == bcd_next($past(digits_o[0]))); // R2
endmodule

// File: tb/test_bcd_ripple_tally.sv
module test_bcd_ripple_tally;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 6;

    logic clk = 1'b0;
    logic clear_n = 1'b0;
    logic pre_a = 1'b0;
    logic pre_b = 1'b0;
    logic ovf_in = 1'b0;
    logic [ND-1:0][3:0] digits;
    logic ovf;
    logic [2:0] taps;
    logic [1:0][3:0] small_digits;
    logic small_ovf;
    logic small_taps;

    int errors = 0;
    int checks = 0;
    int ref_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_ripple_tally i_bcd_ripple_tally (
        .clk(clk), .clear_n(clear_n), .pre_a(pre_a), .pre_b(pre_b),
        .ovf_in(ovf_in), .digits_o(digits), .ovf_o(ovf), .taps_o(taps)
    );

    bcd_ripple_tally #(.NUM_DECADES(2), .TAP_FIRST(0), .NUM_TAPS(1)) i_bcd_ripple_tally_small (
        .clk(clk), .clear_n(clear_n), .pre_a(pre_a), .pre_b(pre_b),
        .ovf_in(ovf_in), .digits_o(small_digits), .ovf_o(small_ovf), .taps_o(small_taps)
    );

    function automatic logic [ND-1:0][3:0] to_bcd(input int v);
        logic [ND-1:0][3:0] r;
        int x = v;
        for (int i = 0; i < ND; i++) begin
            r[i] = 4'(x % 10);
            x = x / 10;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_a(input int n);
        for (int i = 0; i < n; i++) begin
            pre_a = 1'b1; wait_cyc(2);
            pre_a = 1'b0; wait_cyc(2);
            if (clear_n) ref_cnt++;
        end
        wait_cyc(3);
    endtask

    task automatic t_reset();
        check("R7 reset digits", 32'(digits), 32'(to_bcd(0)));
        check("R7 reset ovf", 32'(ovf), 0);
        @(negedge clk); clear_n = 1'b1; wait_cyc(3);
    endtask

    task automatic t_pin_a();
        pulse_a(5);
        check("R3 pin a alone", 32'(digits), 32'(to_bcd(ref_cnt)));
    endtask

    task automatic t_pin_b();
        for (int i = 0; i < 4; i++) begin
            pre_b = 1'b1; wait_cyc(2);
            pre_b = 1'b0; wait_cyc(2);
            ref_cnt++;
        end
        wait_cyc(3);
        check("R3 pin b alone", 32'(digits), 32'(to_bcd(ref_cnt)));
    endtask

    task automatic t_rise_only();
        pre_a = 1'b1; wait_cyc(6);
        check("R2 rise no count", 32'(digits), 32'(to_bcd(ref_cnt)));
        pre_a = 1'b0; wait_cyc(6); ref_cnt++;
        check("R2 fall counts one", 32'(digits), 32'(to_bcd(ref_cnt)));
    endtask

    task automatic t_overlap();
        pre_a = 1'b1; wait_cyc(3);
        pre_b = 1'b1; wait_cyc(3);
        pre_a = 1'b0; wait_cyc(6);
        check("R4 overlap no count", 32'(digits), 32'(to_bcd(ref_cnt)));
        pre_b = 1'b0; wait_cyc(6); ref_cnt++;
        check("R4 overlap single count", 32'(digits), 32'(to_bcd(ref_cnt)));
    endtask

    task automatic t_wrap_small();
        pulse_a(99 - (ref_cnt % 100));
        check("R1 small at 99", 32'(small_digits), 32'h99);
        pulse_a(1);
        check("R6 small wraps to 00", 32'(small_digits), 32'h00);
        check("R5 main carry at hundred", 32'(digits), 32'(to_bcd(ref_cnt)));
    endtask

    task automatic t_climb();
        pulse_a(999 - ref_cnt);
        check("R1 main at 999", 32'(digits), 32'(to_bcd(999)));
        pulse_a(1);
        check("R5 ripple 999 to 1000", 32'(digits), 32'(to_bcd(1000)));
        pulse_a(7999 - ref_cnt);
        check("R10 taps low at 7999", 32'(taps), 0);
        pulse_a(1);
        check("R10 tap0 at 8000", 32'(taps), 32'h1);
        check("R5 digits at 8000", 32'(digits), 32'(to_bcd(ref_cnt)));
    endtask

    task automatic t_overflow();
        ovf_in = 1'b1; wait_cyc(8);
        check("R9 ovf rise ignored", 32'(ovf), 0);
        ovf_in = 1'b0; wait_cyc(6);
        check("R8 ovf set on fall", 32'(ovf), 1);
        ovf_in = 1'b1; wait_cyc(4); ovf_in = 1'b0; wait_cyc(4);
        pulse_a(3);
        check("R8 ovf stays set", 32'(ovf), 1);
    endtask

    task automatic t_clear();
        @(negedge clk); clear_n = 1'b0;
        ref_cnt = 0;
        pulse_a(3);
        check("R7 clear zero digits", 32'(digits), 32'(to_bcd(0)));
        check("R7 clear zero ovf", 32'(ovf), 0);
        clear_n = 1'b1; wait_cyc(4);
        check("R7 no count after release", 32'(digits), 32'(to_bcd(0)));
        pulse_a(2);
        check("R7 counts resume", 32'(digits), 32'(to_bcd(ref_cnt)));
    endtask

    initial begin
        fork
            begin
                wait_cyc(4);
                t_reset();
                t_pin_a();
                t_pin_b();
                t_rise_only();
                t_overlap();
                t_wrap_small();
                t_climb();
                t_overflow();
                t_clear();
            end
            begin
                wait_cyc(150000);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule